// File: doc/BRIEF.md
# Associative Translation Buffer Search with Zone Protection

This block holds a small, fully associative table of address translations and searches it for one virtual address in a single cycle. Each slot carries a tag word (effective page number, page-size code, valid flag), a data word (real page number, zone selector, write and execute enables) and an 8-bit owner ID. A lookup supplies the virtual address, the kind of access, the privilege level, the current process ID and a 32-bit zone protection word. The block reports one of three outcomes: hit, miss or protection fault. On a hit it also returns the translated page number, the page size, the slot number and the granted rights.

Every slot that matches on address and owner is then passed through a 2-bit zone code. The code can hide the slot from user code, keep the slot's own rights, or widen them by privilege. The lowest-numbered slot that survives all of these filters decides the outcome, even when that outcome is a fault. Slots are loaded through a one-cycle write port, and the search result is registered on the clock edge after the request.

Top module: `tlb_zone_lookup`

## Requirements
- R1: After reset `rs_valid` is 0 and every slot is invalid, so any lookup returns a miss.
- R2: The page-size code at tag bits 9:7 selects 1 KB × 4^code (1 KB to 16 MB). A valid slot (tag bit 6 set) matches on address when the virtual address and the tag agree in every bit at or above log2 of that size.
- R3: A slot whose owner ID is 0 matches under any process ID. Any other owner ID must equal `cur_pid`.
- R4: Zone selector z sits at data bits 7:4. Its 2-bit code is read from `zpr` bits [31−2z : 30−2z], so zone 0 uses bits 31:30.
- R5: Code 0 hides the slot from user accesses, and the search moves on to higher slots. For supervisor accesses, code 0 behaves like code 1.
- R6: Code 1 grants write from data bit 8 and execute from data bit 9. Code 2 grants both to supervisor accesses only (user accesses keep the slot's bits). Code 3 grants both to every access.
- R7: A zone selector above the parameter `ZONE_MAX` is treated as code 1. With `PROT_EN` = 0, every slot is treated as code 1.
- R8: Read is always granted on a match. `lk_acc` is encoded 0 = read, 1 = write, 2 = execute, 3 = read. A write without write right, or an execute without execute right, gives a fault. On a fault `rs_idx` and `rs_perm` describe the deciding slot.
- R9: The lowest-indexed slot that passes the address, owner and zone checks decides the outcome. A fault there is final, even if a higher slot would hit.
- R10: A request with `lk_valid` high yields `rs_valid` high on the next edge, with exactly one of hit, miss or fault set. A hit returns data bits 31:10 as `rs_ppn`, the size code and the slot index. `rs_perm` is {execute, write, read}. A miss returns zeros in `rs_ppn`, `rs_size`, `rs_idx` and `rs_perm`.
- R11: A write stores `wr_tag`, `wr_data` and `wr_tid` into slot `wr_idx` on the clock edge. A lookup issued in the same cycle sees the slot's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | IDX_W | Slot to write |
| wr_tag | input | 32 | Tag word: page number 31:10, size code 9:7, valid 6 |
| wr_data | input | 32 | Data word: real page 31:10, execute 9, write 8, zone 7:4 |
| wr_tid | input | 8 | Owner ID (0 = any process) |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor |
| cur_pid | input | 8 | Current process ID |
| zpr | input | 32 | Zone protection word, two bits per zone |
| rs_valid | output | 1 | Result present |
| rs_hit | output | 1 | Translation succeeded |
| rs_miss | output | 1 | No slot decided |
| rs_fault | output | 1 | Deciding slot denied the access |
| rs_ppn | output | 22 | Real page number on hit |
| rs_size | output | 3 | Page-size code on hit |
| rs_idx | output | IDX_W | Deciding slot |
| rs_perm | output | 3 | Granted rights {execute, write, read} |

## Verification
The bench builds two copies side by side with 16 slots and `ZONE_MAX` = 11. One copy has zone protection enabled and the other has it disabled, so every lookup exercises both the zone filter and the forced code-1 path. With `ZONE_MAX` below 15, selectors 12 to 15 can be chosen, which brings the out-of-range rule within reach. A narrow address window combined with random sizes up to 16 MB makes overlapping slots common, so the priority order and faults that block a later hit occur often.

// File: rtl/tlbz_pkg.sv
package tlbz_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_ALT   = 2'd3
  } acc_t;

  localparam int PPN_W     = 22;
  localparam int BASE_SH   = 10;
  localparam int VALID_BIT = 6;
  localparam int WR_BIT    = 8;
  localparam int EX_BIT    = 9;

  // keep-mask for the page-number part of an address at a given size code
  function automatic logic [31:0] page_mask(input logic [2:0] sz);
    return 32'hFFFF_FFFF << (BASE_SH + 2 * int'(sz));
  endfunction

  // two-bit zone code for selector z, zone 0 in the top bits
  function automatic logic [1:0] zone_code(input logic [31:0] zw, input logic [3:0] z);
    logic [4:0] lo;
    lo = 5'd30 - {z, 1'b0};
    return zw[lo +: 2];
  endfunction

endpackage

// File: rtl/tlbz_store.sv
module tlbz_store #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_tag,
  input  logic [31:0]      wr_data,
  input  logic [7:0]       wr_tid,
  output logic [31:0]      tag_q  [ENTRIES],
  output logic [31:0]      data_q [ENTRIES],
  output logic [7:0]       tid_q  [ENTRIES]
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
        tid_q[i]  <= '0;
      end else if (wr_en && (int'(wr_idx) == i)) begin
        tag_q[i]  <= wr_tag;
        data_q[i] <= wr_data;
        tid_q[i]  <= wr_tid;
      end
    end
  end

endmodule

// File: rtl/tlbz_entry_eval.sv
module tlbz_entry_eval
  import tlbz_pkg::*;
#(
  parameter int ZONE_MAX = 15,
  parameter bit PROT_EN  = 1'b1
) (
  input  logic [31:0] tag,
  input  logic [31:0] data,
  input  logic [7:0]  tid,
  input  logic [31:0] vaddr,
  input  acc_t        acc,
  input  logic        user,
  input  logic [7:0]  pid,
  input  logic [31:0] zpr,
  output logic        cand,
  output logic        w_ok,
  output logic        x_ok,
  output logic        deny
);

  logic       addr_ok, id_ok, zone_skip, boost;
  logic [3:0] zsel;
  logic [1:0] zc;
  wire        unused_low = ^data[3:0];

  assign addr_ok = tag[VALID_BIT] && (((vaddr ^ tag) & page_mask(tag[9:7])) == '0);
  assign id_ok   = (tid == 8'd0) || (tid == pid);
  assign zsel    = data[7:4];

  always_comb begin
    if (!PROT_EN || int'(zsel) > ZONE_MAX) zc = 2'd1;
    else                                   zc = zone_code(zpr, zsel);
  end

  assign zone_skip = (zc == 2'd0) && user;
  assign boost     = (zc == 2'd3) || ((zc == 2'd2) && !user);
  assign w_ok      = data[WR_BIT] || boost;
  assign x_ok      = data[EX_BIT] || boost;
  assign cand      = addr_ok && id_ok && !zone_skip;
  assign deny      = ((acc == ACC_WRITE) && !w_ok) || ((acc == ACC_EXEC) && !x_ok);

endmodule

// File: rtl/tlbz_prio.sv
module tlbz_prio #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     pick,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    pick = '0;
    idx  = '0;
    any  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        pick[i] = 1'b1;
        idx     = IDX_W'(i);
        any     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tlb_zone_lookup.sv
module tlb_zone_lookup
  import tlbz_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int ZONE_MAX = 15,
  parameter bit PROT_EN  = 1'b1,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_tag,
  input  logic [31:0]      wr_data,
  input  logic [7:0]       wr_tid,
  input  logic             lk_valid,
  input  logic [31:0]      lk_vaddr,
  input  logic [1:0]       lk_acc,
  input  logic             lk_user,
  input  logic [7:0]       cur_pid,
  input  logic [31:0]      zpr,
  output logic             rs_valid,
  output logic             rs_hit,
  output logic             rs_miss,
  output logic             rs_fault,
  output logic [PPN_W-1:0] rs_ppn,
  output logic [2:0]       rs_size,
  output logic [IDX_W-1:0] rs_idx,
  output logic [2:0]       rs_perm
);

  logic [31:0]        tag_q  [ENTRIES];
  logic [31:0]        data_q [ENTRIES];
  logic [7:0]         tid_q  [ENTRIES];
  logic [ENTRIES-1:0] cand_vec, w_vec, x_vec, deny_vec, pick_vec;
  logic [IDX_W-1:0]   pick_idx;
  logic               pick_any;
  acc_t               acc;

  assign acc = acc_t'(lk_acc);

  tlbz_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_tag(wr_tag), .wr_data(wr_data), .wr_tid(wr_tid),
    .tag_q(tag_q), .data_q(data_q), .tid_q(tid_q)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_eval
    tlbz_entry_eval #(.ZONE_MAX(ZONE_MAX), .PROT_EN(PROT_EN)) u_eval (
      .tag(tag_q[i]), .data(data_q[i]), .tid(tid_q[i]),
      .vaddr(lk_vaddr), .acc(acc), .user(lk_user), .pid(cur_pid), .zpr(zpr),
      .cand(cand_vec[i]), .w_ok(w_vec[i]), .x_ok(x_vec[i]), .deny(deny_vec[i])
    );
  end

  tlbz_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
    .req(cand_vec), .pick(pick_vec), .idx(pick_idx), .any(pick_any)
  );

  // named events for the checker
  logic        sel_deny, sel_w, sel_x, will_hit;
  logic [31:0] sel_tag, sel_data;

  assign sel_deny = |(pick_vec & deny_vec);
  assign sel_w    = |(pick_vec & w_vec);
  assign sel_x    = |(pick_vec & x_vec);
  assign sel_tag  = tag_q[pick_idx];
  assign sel_data = data_q[pick_idx];
  assign will_hit = pick_any && !sel_deny;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_miss  <= 1'b0;
      rs_fault <= 1'b0;
      rs_ppn   <= '0;
      rs_size  <= '0;
      rs_idx   <= '0;
      rs_perm  <= '0;
    end else begin
      rs_valid <= lk_valid;
      rs_hit   <= lk_valid && will_hit;
      rs_miss  <= lk_valid && !pick_any;
      rs_fault <= lk_valid && pick_any && sel_deny;
      if (lk_valid) begin
        rs_ppn  <= will_hit ? sel_data[31:BASE_SH] : '0;
        rs_size <= will_hit ? sel_tag[9:7] : '0;
        rs_idx  <= pick_any ? pick_idx : '0;
        rs_perm <= pick_any ? {sel_x, sel_w, 1'b1} : 3'b000;
      end
    end
  end

  wire unused_tag_low = ^sel_tag[6:0] ^ ^sel_data[9:0];

endmodule

// File: rtl/tlbz_checker.sv
module tlbz_checker #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [1:0]         lk_acc,
  input logic               rs_valid,
  input logic               rs_hit,
  input logic               rs_miss,
  input logic               rs_fault,
  input logic [IDX_W-1:0]   rs_idx,
  input logic [2:0]         rs_perm,
  input logic [ENTRIES-1:0] cand_vec,
  input logic [ENTRIES-1:0] pick_vec
);

  AST_RESULT_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);  // R10
  AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);  // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> $onehot({rs_hit, rs_miss, rs_fault}));  // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> !(rs_hit || rs_miss || rs_fault));  // R10
  AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rs_miss |-> (rs_idx == '0 && rs_perm == 3'b000));  // R10
  AST_READ_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_hit || rs_fault) |-> rs_perm[0]);  // R8
  AST_WRITE_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_acc == 2'd1) |=> (rs_hit |-> rs_perm[1]));  // R8
  AST_EXEC_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_acc == 2'd2) |=> (rs_hit |-> rs_perm[2]));  // R8
  AST_SINGLE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_vec));  // R9
  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cand_vec) == (|pick_vec)) && ((pick_vec & cand_vec) == pick_vec)
    && (((pick_vec - 1'b1) & cand_vec) == '0));  // R9

endmodule

bind tlb_zone_lookup tlbz_checker #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_acc(lk_acc),
  .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_fault(rs_fault),
  .rs_idx(rs_idx), .rs_perm(rs_perm), .cand_vec(cand_vec), .pick_vec(pick_vec)
);

// File: tb/tlb_zone_lookup_test.sv
`timescale 1ns/1ps
module tlb_zone_lookup_test;

  localparam int N  = 16;
  localparam int ZM = 11;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0]   wr_tag = '0, wr_data = '0;
  logic [7:0]    wr_tid = '0;
  logic          lk_valid = 1'b0;
  logic [31:0]   lk_vaddr = '0;
  logic [1:0]    lk_acc = '0;
  logic          lk_user = 1'b0;
  logic [7:0]    cur_pid = '0;
  logic [31:0]   zpr = '0;

  logic          a_valid, a_hit, a_miss, a_fault, b_valid, b_hit, b_miss, b_fault;
  logic [21:0]   a_ppn, b_ppn;
  logic [2:0]    a_size, b_size, a_perm, b_perm;
  logic [IW-1:0] a_idx, b_idx;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [31:0] m_tag [N];
  logic [31:0] m_data[N];
  logic [7:0]  m_tid [N];

  always #2.5 clk = ~clk;

  tlb_zone_lookup #(.ENTRIES(N), .ZONE_MAX(ZM), .PROT_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_data(wr_data), .wr_tid(wr_tid), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_acc(lk_acc), .lk_user(lk_user), .cur_pid(cur_pid), .zpr(zpr),
    .rs_valid(a_valid), .rs_hit(a_hit), .rs_miss(a_miss), .rs_fault(a_fault),
    .rs_ppn(a_ppn), .rs_size(a_size), .rs_idx(a_idx), .rs_perm(a_perm));

  tlb_zone_lookup #(.ENTRIES(N), .ZONE_MAX(ZM), .PROT_EN(1'b0)) uut_np (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_data(wr_data), .wr_tid(wr_tid), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_acc(lk_acc), .lk_user(lk_user), .cur_pid(cur_pid), .zpr(zpr),
    .rs_valid(b_valid), .rs_hit(b_hit), .rs_miss(b_miss), .rs_fault(b_fault),
    .rs_ppn(b_ppn), .rs_size(b_size), .rs_idx(b_idx), .rs_perm(b_perm));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] size_bytes(input logic [2:0] c);
    case (c)
      3'd0: return 32'd1024;
      3'd1: return 32'd4096;
      3'd2: return 32'd16384;
      3'd3: return 32'd65536;
      3'd4: return 32'd262144;
      3'd5: return 32'd1048576;
      3'd6: return 32'd4194304;
      default: return 32'd16777216;
    endcase
  endfunction

  // outcome: 0 miss, 1 hit, 2 fault
  task automatic model(input bit prot, output int oc, output logic [21:0] ppn,
                       output logic [2:0] sz, output logic [3:0] idx, output logic [2:0] perm);
    logic [31:0] t, d, bytes;
    int z, code;
    bit w, x;
    oc = 0; ppn = '0; sz = '0; idx = '0; perm = '0;
    for (int i = 0; i < N; i++) begin
      t = m_tag[i]; d = m_data[i];
      if (!t[6]) continue;
      bytes = size_bytes(t[9:7]);
      if ((lk_vaddr / bytes) != (t / bytes)) continue;
      if (m_tid[i] != 8'd0 && m_tid[i] != cur_pid) continue;
      z = int'(d[7:4]);
      code = int'((zpr >> (30 - 2 * z)) & 32'd3);
      if (z > ZM || !prot) code = 1;
      if (code == 0 && lk_user) continue;
      w = d[8]; x = d[9];
      if (code == 3 || (code == 2 && !lk_user)) begin w = 1'b1; x = 1'b1; end
      idx = 4'(i); perm = {x, w, 1'b1};
      if ((lk_acc == 2'd1 && !w) || (lk_acc == 2'd2 && !x)) oc = 2;
      else begin oc = 1; ppn = d[31:10]; sz = t[9:7]; end
      break;
    end
  endtask

  task automatic compare(input string req);
    int oc;
    logic [21:0] ppn;
    logic [2:0] sz, perm;
    logic [3:0] idx;
    model(1'b1, oc, ppn, sz, idx, perm);
    chk(req, "outcome", {29'd0, a_fault, a_hit, a_miss},
        oc == 0 ? 32'd1 : (oc == 1 ? 32'd2 : 32'd4));
    chk(req, "index", 32'(a_idx), 32'(idx));
    chk(req, "perm", 32'(a_perm), 32'(perm));
    chk(req, "ppn", 32'(a_ppn), 32'(ppn));
    chk(req, "size", 32'(a_size), 32'(sz));
    model(1'b0, oc, ppn, sz, idx, perm);
    chk("R7", "noprot outcome", {29'd0, b_fault, b_hit, b_miss},
        oc == 0 ? 32'd1 : (oc == 1 ? 32'd2 : 32'd4));
    chk("R7", "noprot perm", 32'(b_perm), 32'(perm));
    chk("R7", "noprot index", 32'(b_idx), 32'(idx));
  endtask

  task automatic put(input int i, input logic [31:0] t, input logic [31:0] d, input logic [7:0] id);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(i); wr_tag = t; wr_data = d; wr_tid = id;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    m_tag[i] = t; m_data[i] = d; m_tid[i] = id;
  endtask

  task automatic look(input string req, input logic [31:0] va, input logic [1:0] acc,
                      input logic usr, input logic [7:0] pid, input logic [31:0] zw);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_acc = acc; lk_user = usr; cur_pid = pid; zpr = zw;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R10", "valid", 32'(a_valid), 32'd1);
    compare(req);
  endtask

  function automatic logic [31:0] mk_tag(input logic [31:0] epn_addr, input logic [2:0] sz);
    return (epn_addr & 32'hFFFF_FC00) | (32'(sz) << 7) | 32'h40;
  endfunction

  function automatic logic [31:0] mk_data(input logic [21:0] rpn, input bit x, input bit w, input logic [3:0] z);
    return {rpn, x, w, z, 4'h0};
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_data[i] = '0; m_tid[i] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "rs_valid after reset", 32'(a_valid), 32'd0);
    look("R1", 32'h0000_0000, 2'd0, 1'b0, 8'd1, 32'hFFFF_FFFF);
    chk("R1", "miss after reset", 32'(a_miss), 32'd1);

    // R2: 16 KB page at 0x10000
    put(3, mk_tag(32'h0001_0000, 3'd2), mk_data(22'h2AB, 1'b0, 1'b0, 4'd1), 8'd0);
    look("R2", 32'h0001_3FFC, 2'd0, 1'b1, 8'd9, 32'h5555_5555);
    chk("R2", "inside page hits", 32'(a_hit), 32'd1);
    look("R2", 32'h0001_4000, 2'd0, 1'b1, 8'd9, 32'h5555_5555);
    chk("R2", "past page misses", 32'(a_miss), 32'd1);

    // R4 / R6: zone 1 uses bits 29:28
    look("R4", 32'h0001_0010, 2'd1, 1'b1, 8'd9, 32'h3000_0000);
    chk("R4", "zone1 code3 write hit", 32'(a_hit), 32'd1);
    look("R6", 32'h0001_0010, 2'd1, 1'b0, 8'd9, 32'h2000_0000);
    chk("R6", "code2 supervisor write", 32'(a_hit), 32'd1);
    look("R6", 32'h0001_0010, 2'd1, 1'b1, 8'd9, 32'h2000_0000);
    chk("R6", "code2 user write faults", 32'(a_fault), 32'd1);
    look("R5", 32'h0001_0010, 2'd0, 1'b1, 8'd9, 32'hC000_0000);
    chk("R5", "code0 user hidden", 32'(a_miss), 32'd1);

    // R3: owner id
    put(7, mk_tag(32'h0080_0000, 3'd1), mk_data(22'h111, 1'b1, 1'b1, 4'd0), 8'd5);
    look("R3", 32'h0080_0100, 2'd0, 1'b0, 8'd5, 32'h5555_5555);
    chk("R3", "matching pid", 32'(a_hit), 32'd1);
    look("R3", 32'h0080_0100, 2'd0, 1'b0, 8'd6, 32'h5555_5555);
    chk("R3", "other pid", 32'(a_miss), 32'd1);

    // R9: slot 2 zone0 hidden from user, slot 5 behind it
    put(2, mk_tag(32'h0004_0000, 3'd1), mk_data(22'h022, 1'b0, 1'b0, 4'd0), 8'd0);
    put(5, mk_tag(32'h0004_0000, 3'd1), mk_data(22'h055, 1'b1, 1'b1, 4'd2), 8'd0);
    look("R9", 32'h0004_0008, 2'd0, 1'b1, 8'd1, 32'h0400_0000);
    chk("R9", "user skips to slot 5", 32'(a_idx), 32'd5);
    look("R9", 32'h0004_0008, 2'd1, 1'b0, 8'd1, 32'h0400_0000);
    chk("R9", "slot 2 fault is final", 32'(a_fault), 32'd1);

    // R7: zone 13 above limit
    put(9, mk_tag(32'h00A0_0000, 3'd0), mk_data(22'h099, 1'b0, 1'b0, 4'd13), 8'd0);
    look("R7", 32'h00A0_0004, 2'd1, 1'b1, 8'd1, 32'hFFFF_FFFF);
    chk("R7", "out-of-range zone uses own bits", 32'(a_fault), 32'd1);

    // R11: write and lookup in same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd7; wr_tag = 32'h0; wr_data = 32'h0; wr_tid = 8'd0;
    lk_valid = 1'b1; lk_vaddr = 32'h0080_0100; lk_acc = 2'd0; lk_user = 1'b0;
    cur_pid = 8'd5; zpr = 32'h5555_5555;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    chk("R11", "old contents seen", 32'(a_hit), 32'd1);
    chk("R11", "old index", 32'(a_idx), 32'd7);
    m_tag[7] = '0; m_data[7] = '0; m_tid[7] = '0;
    look("R11", 32'h0080_0100, 2'd0, 1'b0, 8'd5, 32'h5555_5555);
    chk("R11", "cleared slot misses", 32'(a_miss), 32'd1);

    // random mix
    void'($urandom(32'd1234));
    for (int k = 0; k < 600; k++) begin
      if ($urandom_range(0, 3) == 0) begin
        logic [31:0] t;
        t = ($urandom & 32'h001F_FC00) | (32'($urandom_range(0, 7)) << 7)
            | (($urandom_range(0, 5) != 0) ? 32'h40 : 32'h0);
        put($urandom_range(0, N - 1), t, $urandom, 8'($urandom_range(0, 3)));
      end else begin
        look("R8", $urandom & 32'h001F_FFFF, 2'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)), 8'($urandom_range(1, 3)), $urandom);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule